// File: doc/BRIEF.md
# Dual-Channel Split DMA FIFO

This block holds one storage array of sixteen 32-bit words (64 bytes) and divides it between two IDE bus-master channels. A configuration byte chooses the division (all to channel 0, all to channel 1, or half to each) and sets each channel's DMA request threshold. The threshold is a fraction of the words that channel owns. Each channel sees a private FIFO with its own push and pop ports, full and empty flags, a fill level and a DMA request line. Every partition keeps its own read and write offsets, which wrap inside the partition's own base and size. Traffic on one channel therefore never touches the other channel's words.

The request line follows the fill level for transfers into the block (receive) and the free space for transfers out of it (transmit). A channel can also be forced to drain. One trigger is its interrupt during a read transfer. The other is the end of a sector, counted in bytes pushed against a 12-bit per-channel sector size. Until software writes a configuration, the block derives one from the channel-enable inputs. A write that would change the division while either partition holds data is refused and raises an error flag.

Top module: `split_dma_fifo`

## Requirements
- R1: Configuration bits 6:5 set the division. 00 gives all 16 words to channel 0. 11 gives all 16 words to channel 1. 01 or 10 gives 8 words to each channel, with channel 0 at words 0-7 and channel 1 at words 8-15.
- R2: In receive mode (rx_dir bit set), a channel's dreq is high when its level is at least its threshold. Channel 0 takes its threshold code from bits 3:2 and channel 1 from bits 1:0. The codes are 00 for all of the partition, 01 for 3/4, 10 for 1/2 and 11 for 1/4.
- R3: In transmit mode (rx_dir bit clear), dreq is high when the free words (size minus level) are at least the threshold.
- R4: A channel that owns zero words never raises dreq. It reports full and empty together, and its pushes are ignored.
- R5: Each channel returns its own words in push order, including across the wrap of its partition, whatever the other channel does.
- R6: A push to a full channel and a pop from an empty channel change nothing. The level never exceeds the partition size.
- R7: When a channel in receive mode has its read flush enabled and its irq is high, dreq is forced high from the next cycle until that partition is empty. With the enable clear, irq has no effect.
- R8: When the end-of-sector flush is enabled and sector_bytes is nonzero, each push adds 4 bytes to a count. When the count reaches sector_bytes, it restarts and a flush starts as in R7.
- R9: Until a configuration is written, cfg_eff is derived from ch_en. It is 8'h04 when only channel 0 is enabled (ch_en=01). It is 8'h61 when only channel 1 is enabled (ch_en=10). Otherwise it is 8'h2a.
- R10: A configuration write is taken when both partitions are empty, and it clears cfg_err and both channels' offsets. A write that changes bits 6:5 while either partition holds data is dropped and sets cfg_err.
- R11: After reset both channels are empty with level 0, cfg_err is low and no dreq is raised in receive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte to write |
| ch_en | input | 2 | Channel enables, used for the derived configuration |
| cfg_eff | output | 8 | Configuration byte in force |
| cfg_err | output | 1 | Set by a refused division change |
| rx_dir | input | 2 | Per channel: 1 receive, 0 transmit |
| push | input | 2 | Per-channel push strobe |
| push_data | input | 64 | Per-channel push word, channel 0 in bits 31:0 |
| pop | input | 2 | Per-channel pop strobe |
| pop_data | output | 64 | Per-channel head word, channel 0 in bits 31:0 |
| full | output | 2 | Per-channel full flag |
| empty | output | 2 | Per-channel empty flag |
| level | output | 10 | Per-channel word count, 5 bits each, channel 0 low |
| dreq | output | 2 | Per-channel DMA request |
| irq | input | 2 | Per-channel interrupt |
| rd_flush_en | input | 2 | Per-channel read flush enable |
| eos_flush_en | input | 2 | Per-channel end-of-sector flush enable |
| sector_bytes | input | 24 | Per-channel sector size in bytes, 12 bits each, channel 0 low |

## Verification
The properties assume that ch_en stays constant while the derived configuration is in force, since changing it would resize a partition that holds data. They also assume that sector_bytes and the flush enables change only while the channel is idle. The stimulus sets these inputs while reset is held or the partitions are empty and never moves them during a transfer. The bench writes every configuration just after a reset, so each intended division is taken. A division change is offered with data present only in the test that expects the refusal.

// File: rtl/split_dma_fifo_pkg.sv
`timescale 1ns/1ps
package split_dma_fifo_pkg;

  typedef enum logic [1:0] {
    DIV_ALL_CH0 = 2'b00,
    DIV_HALF_A  = 2'b01,
    DIV_HALF_B  = 2'b10,
    DIV_ALL_CH1 = 2'b11
  } div_e;

  // threshold in words for a partition of sz words
  function automatic int unsigned thr_of(input int unsigned sz, input logic [1:0] code);
    case (code)
      2'b00:   return sz;
      2'b01:   return sz - sz / 4;
      2'b10:   return sz / 2;
      default: return sz / 4;
    endcase
  endfunction

  function automatic int unsigned part_size(input logic [1:0] div, input int ch,
                                            input int unsigned depth);
    case (div_e'(div))
      DIV_ALL_CH0: return (ch == 0) ? depth : 0;
      DIV_ALL_CH1: return (ch == 0) ? 0 : depth;
      default:     return depth / 2;
    endcase
  endfunction

endpackage

// File: rtl/split_dma_fifo_cfg.sv
`timescale 1ns/1ps
module split_dma_fifo_cfg (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic [1:0] ch_en,
  input  logic       both_empty,
  output logic [7:0] cfg_eff,
  output logic       load,
  output logic       err
);
  logic       expl_q, expl_d;
  logic [7:0] cfg_q, cfg_d;
  logic       err_q, err_d;
  logic [7:0] derived;
  logic       take, refuse;

  always_comb begin
    case (ch_en)
      2'b01:   derived = 8'h04;
      2'b10:   derived = 8'h61;
      default: derived = 8'h2a;
    endcase
  end

  assign cfg_eff = expl_q ? cfg_q : derived;
  assign take    = we && (both_empty || (wdata[6:5] == cfg_eff[6:5]));
  assign refuse  = we && !take;
  assign load    = we && both_empty;

  always_comb begin
    expl_d = expl_q;
    cfg_d  = cfg_q;
    err_d  = err_q;
    if (take) begin
      expl_d = 1'b1;
      cfg_d  = wdata;
    end
    if (load)        err_d = 1'b0;
    else if (refuse) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      expl_q <= 1'b0;
      cfg_q  <= 8'h00;
      err_q  <= 1'b0;
    end else begin
      expl_q <= expl_d;
      cfg_q  <= cfg_d;
      err_q  <= err_d;
    end
  end

  assign err = err_q;

  p_refuse_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (we && !both_empty && (wdata[6:5] != cfg_eff[6:5])) |=> (err && $stable(cfg_eff)));
  p_take_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (we && both_empty) |=> ((cfg_eff == $past(wdata)) && !err));

endmodule

// File: rtl/split_dma_fifo_chan.sv
`timescale 1ns/1ps
module split_dma_fifo_chan #(
  parameter int DEPTH = 16,
  parameter int SECW  = 12,
  parameter int BPW   = 4,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            clr,
  input  logic [AW-1:0]   base,
  input  logic [LW-1:0]   size,
  input  logic [1:0]      thr_code,
  input  logic            rx_dir,
  input  logic            push,
  input  logic            pop,
  input  logic            irq,
  input  logic            rd_flush_en,
  input  logic            eos_flush_en,
  input  logic [SECW-1:0] sec_bytes,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [AW-1:0]   rd_addr,
  output logic            full,
  output logic            empty,
  output logic [LW-1:0]   level,
  output logic            dreq
);
  import split_dma_fifo_pkg::*;

  logic [AW-1:0]   wr_off_q, wr_off_d, rd_off_q, rd_off_d;
  logic [LW-1:0]   lvl_q, lvl_d;
  logic            flush_q, flush_d;
  logic [SECW-1:0] bcnt_q, bcnt_d;
  logic [SECW:0]   bsum;
  logic            do_push, do_pop, sec_hit, trig, thr_met;
  logic [LW-1:0]   thr, space;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] off, input logic [LW-1:0] sz);
    return ({1'b0, off} == sz - LW'(1)) ? '0 : off + AW'(1);
  endfunction

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == size);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign bsum    = {1'b0, bcnt_q} + (SECW+1)'(BPW);
  assign sec_hit = do_push && (sec_bytes != '0) && (bsum >= {1'b0, sec_bytes});
  assign trig    = (irq && rd_flush_en && rx_dir) || (eos_flush_en && sec_hit);
  assign thr     = LW'(thr_of(32'(size), thr_code));
  assign space   = size - lvl_q;
  assign thr_met = rx_dir ? (lvl_q >= thr) : (space >= thr);
  assign dreq    = (size != '0) && ((flush_q && !empty) || thr_met);

  always_comb begin
    wr_off_d = wr_off_q;
    rd_off_d = rd_off_q;
    lvl_d    = lvl_q + LW'(do_push) - LW'(do_pop);
    bcnt_d   = bcnt_q;
    flush_d  = trig ? 1'b1 : (empty ? 1'b0 : flush_q);
    if (do_push) begin
      wr_off_d = step(wr_off_q, size);
      bcnt_d   = sec_hit ? '0 : bsum[SECW-1:0];
    end
    if (do_pop) rd_off_d = step(rd_off_q, size);
    if (clr) begin
      wr_off_d = '0;
      rd_off_d = '0;
      lvl_d    = '0;
      bcnt_d   = '0;
      flush_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_off_q <= '0;
      rd_off_q <= '0;
      lvl_q    <= '0;
      bcnt_q   <= '0;
      flush_q  <= 1'b0;
    end else begin
      wr_off_q <= wr_off_d;
      rd_off_q <= rd_off_d;
      lvl_q    <= lvl_d;
      bcnt_q   <= bcnt_d;
      flush_q  <= flush_d;
    end
  end

  assign wr_en   = do_push;
  assign wr_addr = base + wr_off_q;
  assign rd_addr = base + rd_off_q;
  assign level   = lvl_q;

  p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    lvl_q <= size);
  p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (full && !pop && !clr) |=> $stable(lvl_q));
  p_empty_hold_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (empty && !push && !clr) |=> (lvl_q == '0));
  p_flush_end_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(flush_q) |-> ($past(empty) || $past(clr)));

endmodule

// File: rtl/split_dma_fifo.sv
`timescale 1ns/1ps
module split_dma_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  parameter int SECW  = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [7:0]                      cfg_wdata,
  input  logic [1:0]                      ch_en,
  output logic [7:0]                      cfg_eff,
  output logic                            cfg_err,
  input  logic [1:0]                      rx_dir,
  input  logic [1:0]                      push,
  input  logic [2*W-1:0]                  push_data,
  input  logic [1:0]                      pop,
  output logic [2*W-1:0]                  pop_data,
  output logic [1:0]                      full,
  output logic [1:0]                      empty,
  output logic [2*($clog2(DEPTH)+1)-1:0]  level,
  output logic [1:0]                      dreq,
  input  logic [1:0]                      irq,
  input  logic [1:0]                      rd_flush_en,
  input  logic [1:0]                      eos_flush_en,
  input  logic [2*SECW-1:0]               sector_bytes
);
  import split_dma_fifo_pkg::*;

  localparam int AW  = $clog2(DEPTH);
  localparam int LW  = AW + 1;
  localparam int BPW = W / 8;
  localparam int NCH = 2;

  logic [1:0]    rst_sync_q;
  logic          rst_ni;
  logic          load;
  logic [W-1:0]  mem [DEPTH];
  logic          wr_en   [NCH];
  logic [AW-1:0] wr_addr [NCH];
  logic [AW-1:0] rd_addr [NCH];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  split_dma_fifo_cfg u_cfg (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .we         (cfg_we),
    .wdata      (cfg_wdata),
    .ch_en      (ch_en),
    .both_empty (&empty),
    .cfg_eff    (cfg_eff),
    .load       (load),
    .err        (cfg_err)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [LW-1:0] psize;
    logic [AW-1:0] pbase;
    assign psize = LW'(part_size(cfg_eff[6:5], c, DEPTH));
    assign pbase = (c == 0 || cfg_eff[6:5] == DIV_ALL_CH1) ? '0 : AW'(DEPTH / 2);

    split_dma_fifo_chan #(.DEPTH(DEPTH), .SECW(SECW), .BPW(BPW), .AW(AW), .LW(LW)) u_chan (
      .clk          (clk),
      .rst_ni       (rst_ni),
      .clr          (load),
      .base         (pbase),
      .size         (psize),
      .thr_code     ((c == 0) ? cfg_eff[3:2] : cfg_eff[1:0]),
      .rx_dir       (rx_dir[c]),
      .push         (push[c]),
      .pop          (pop[c]),
      .irq          (irq[c]),
      .rd_flush_en  (rd_flush_en[c]),
      .eos_flush_en (eos_flush_en[c]),
      .sec_bytes    (sector_bytes[c*SECW +: SECW]),
      .wr_en        (wr_en[c]),
      .wr_addr      (wr_addr[c]),
      .rd_addr      (rd_addr[c]),
      .full         (full[c]),
      .empty        (empty[c]),
      .level        (level[c*LW +: LW]),
      .dreq         (dreq[c])
    );

    assign pop_data[c*W +: W] = mem[rd_addr[c]];
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (wr_en[c]) mem[wr_addr[c]] <= push_data[c*W +: W];
    end
  end

  p_zero_ch0_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_eff[6:5] == 2'b11) |-> (!dreq[0] && full[0] && empty[0]));
  p_zero_ch1_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_eff[6:5] == 2'b00) |-> (!dreq[1] && full[1] && empty[1]));
  p_no_collide_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en[0] && wr_en[1]) |-> (wr_addr[0] != wr_addr[1]));

endmodule

// File: tb/split_dma_fifo_bench.sv
`timescale 1ns/1ps
module split_dma_fifo_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_wdata;
  logic [1:0]  ch_en;
  logic [7:0]  cfg_eff;
  logic        cfg_err;
  logic [1:0]  rx_dir, push, pop, full, empty, dreq, irq, rd_flush_en, eos_flush_en;
  logic [63:0] push_data, pop_data;
  logic [9:0]  level;
  logic [23:0] sector_bytes;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  split_dma_fifo u_split_dma_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .ch_en(ch_en),
    .cfg_eff(cfg_eff), .cfg_err(cfg_err), .rx_dir(rx_dir), .push(push),
    .push_data(push_data), .pop(pop), .pop_data(pop_data), .full(full), .empty(empty),
    .level(level), .dreq(dreq), .irq(irq), .rd_flush_en(rd_flush_en),
    .eos_flush_en(eos_flush_en), .sector_bytes(sector_bytes)
  );

  typedef struct packed {
    logic [7:0] cfg;
    logic [1:0] rx;
    logic [4:0] n0, n1;
    logic [1:0] full, dreq;
    logic [4:0] lv0, lv1;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{8'h00, 2'b11, 5'd16, 5'd0,  2'b11, 2'b01, 5'd16, 5'd0},   // R1 R2
    '{8'h00, 2'b11, 5'd15, 5'd0,  2'b10, 2'b00, 5'd15, 5'd0},   // R2
    '{8'h04, 2'b11, 5'd12, 5'd0,  2'b10, 2'b01, 5'd12, 5'd0},   // R2 3/4
    '{8'h04, 2'b11, 5'd11, 5'd0,  2'b10, 2'b00, 5'd11, 5'd0},   // R2
    '{8'h28, 2'b11, 5'd4,  5'd7,  2'b00, 2'b01, 5'd4,  5'd7},   // R1 R2
    '{8'h4f, 2'b11, 5'd8,  5'd1,  2'b01, 2'b01, 5'd8,  5'd1},   // R1 R2 R6
    '{8'h60, 2'b11, 5'd3,  5'd16, 2'b11, 2'b10, 5'd0,  5'd16},  // R1 R4
    '{8'h63, 2'b11, 5'd0,  5'd3,  2'b01, 2'b00, 5'd0,  5'd3},   // R2 R4
    '{8'h2a, 2'b00, 5'd4,  5'd5,  2'b00, 2'b01, 5'd4,  5'd5},   // R3
    '{8'h00, 2'b00, 5'd0,  5'd0,  2'b10, 2'b01, 5'd0,  5'd0},   // R3 R4
    '{8'h60, 2'b00, 5'd0,  5'd1,  2'b01, 2'b00, 5'd0,  5'd1},   // R3 R4
    '{8'h2f, 2'b00, 5'd6,  5'd7,  2'b00, 2'b01, 5'd6,  5'd7}    // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cfg_we = 1'b0; push = '0; pop = '0; irq = '0;
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_wdata = v; cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic push_ch(input int c, input logic [31:0] d);
    push[c] = 1'b1; push_data[c*32 +: 32] = d;
    tick();
    push[c] = 1'b0;
  endtask

  task automatic pop_ch(input int c);
    pop[c] = 1'b1;
    tick();
    pop[c] = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog R11 act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    ch_en = 2'b11; rx_dir = 2'b11; push_data = '0; cfg_wdata = '0;
    rd_flush_en = '0; eos_flush_en = '0; sector_bytes = '0;
    do_reset();

    // R11 reset state, R9 derived config with both enabled
    chk("R11 empty", 32'(empty), 32'h3);
    chk("R11 level", 32'(level), 32'h0);
    chk("R11 dreq", 32'(dreq), 32'h0);
    chk("R11 err", 32'(cfg_err), 32'h0);
    chk("R9 both", 32'(cfg_eff), 32'h2a);

    // vector table: R1 R2 R3 R4 R6
    for (int i = 0; i < 12; i++) begin
      rx_dir = VEC[i].rx;
      do_reset();
      write_cfg(VEC[i].cfg);
      for (int k = 0; k < 16; k++) begin
        push[0] = (k < int'(VEC[i].n0));
        push[1] = (k < int'(VEC[i].n1));
        push_data = {32'hB000_0000 + k, 32'hA000_0000 + k};
        tick();
      end
      push = '0;
      chk("R1 full", 32'(full), 32'(VEC[i].full));
      chk("R2 R3 R4 dreq", 32'(dreq), 32'(VEC[i].dreq));
      chk("R6 level0", 32'(level[4:0]), 32'(VEC[i].lv0));
      chk("R6 level1", 32'(level[9:5]), 32'(VEC[i].lv1));
    end

    // R9 single-channel derived configs
    ch_en = 2'b01; do_reset();
    chk("R9 only ch0", 32'(cfg_eff), 32'h04);
    ch_en = 2'b10; do_reset();
    chk("R9 only ch1", 32'(cfg_eff), 32'h61);
    ch_en = 2'b11; do_reset();

    // R5 ordering and isolation across partition wrap
    rx_dir = 2'b11;
    write_cfg(8'h2a);
    for (int r = 0; r < 2; r++) begin
      for (int k = 0; k < 5; k++) begin
        push = 2'b11;
        push_data = {32'hB500_0000 + 32'(r*8 + k), 32'hA500_0000 + 32'(r*8 + k)};
        tick();
      end
      push = '0;
      for (int k = 0; k < 5; k++) begin
        chk("R5 ch0 data", pop_data[31:0], 32'hA500_0000 + 32'(r*8 + k));
        chk("R5 ch1 data", pop_data[63:32], 32'hB500_0000 + 32'(r*8 + k));
        pop = 2'b11;
        tick();
      end
      pop = '0;
    end

    // R6 overflow and underflow ignored
    for (int k = 0; k < 9; k++) push_ch(0, 32'hC000_0000 + k);
    chk("R6 cap", 32'(level[4:0]), 32'd8);
    for (int k = 0; k < 8; k++) begin
      chk("R6 order", pop_data[31:0], 32'hC000_0000 + k);
      pop_ch(0);
    end
    pop_ch(0);
    chk("R6 underflow", 32'(level[4:0]), 32'd0);
    chk("R6 empty", 32'(empty), 32'h3);

    // R10 refused and accepted division change
    push_ch(0, 32'hD000_0001);
    write_cfg(8'h00);
    chk("R10 refuse cfg", 32'(cfg_eff), 32'h2a);
    chk("R10 refuse err", 32'(cfg_err), 32'h1);
    chk("R10 data kept", pop_data[31:0], 32'hD000_0001);
    pop_ch(0);
    write_cfg(8'h00);
    chk("R10 take cfg", 32'(cfg_eff), 32'h00);
    chk("R10 take err", 32'(cfg_err), 32'h0);

    // R7 read flush on interrupt
    do_reset();
    write_cfg(8'h2a);
    push_ch(0, 32'h1); push_ch(0, 32'h2);
    irq[0] = 1'b1; tick(); irq[0] = 1'b0;
    chk("R7 no enable", 32'(dreq), 32'h0);
    rd_flush_en[0] = 1'b1;
    irq[0] = 1'b1; tick(); irq[0] = 1'b0;
    chk("R7 forced", 32'(dreq), 32'h1);
    pop_ch(0);
    chk("R7 held", 32'(dreq), 32'h1);
    pop_ch(0);
    chk("R7 drained", 32'(dreq), 32'h0);
    rd_flush_en = '0;

    // R8 end-of-sector flush, 12-byte sector = 3 words
    do_reset();
    write_cfg(8'h2a);
    sector_bytes[11:0] = 12'd12; eos_flush_en[0] = 1'b1;
    push_ch(0, 32'h1); push_ch(0, 32'h2);
    chk("R8 before", 32'(dreq), 32'h0);
    push_ch(0, 32'h3);
    chk("R8 boundary", 32'(dreq), 32'h1);
    repeat (3) pop_ch(0);
    chk("R8 drained", 32'(dreq), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule